// File: doc/BRIEF.md
# Two-Phase Run Detector with Latched Flag

This block is a clocked Moore state machine that watches a serial bit input for two separate runs. The first run is two consecutive 1s. The second run is three consecutive 0s, and it may come any number of cycles after the first. Once both runs have been seen in that order, the flag output goes high. It stays high until the hold input clears the machine.

While the hold input is high, the machine is held in its idle state and the flag stays low. When hold is released, detection starts from scratch. The flag comes from the state register alone, so it only changes on a rising clock edge. Input synchronization and debouncing are the job of the surrounding logic.

There are six states:

- IDLE: no 1 counted.
- ONE: one 1 seen.
- ARMED: the two-1s phase is complete.
- ZERO1: one 0 seen after arming.
- ZERO2: two 0s seen after arming.
- DONE: the flag is raised.

The transitions are as follows:

- IDLE goes to ONE on a 1.
- ONE goes to ARMED on a 1, or back to IDLE on a 0.
- ARMED goes to ZERO1 on a 0.
- ZERO1 goes to ZERO2 on a 0, or back to ARMED on a 1.
- ZERO2 goes to DONE on a 0, or back to ARMED on a 1.
- DONE stays in DONE.
- From any state, a sampled hold forces IDLE.

Top module: `run_pair_detector`

## Requirements
- R1: An active-low `rst_n` asynchronously forces the idle state, and `flag_o` reads 0 while reset is low.
- R2: If `hold_i` is 1 at a rising edge, `flag_o` is 0 after that edge, and the bit history seen before that edge is discarded.
- R3: `flag_o` is a Moore output. It never changes between rising clock edges, whatever `bit_i` and `hold_i` do in between.
- R4: After hold is released, the shortest bit stream that raises the flag is 1,1,0,0,0. `flag_o` becomes 1 right after the edge that samples the third 0, and stays 0 after the edge that samples the second 0.
- R5: Any bits may fall between the two-1s run and the three-0s run without stopping detection.
- R6: A 0 sampled after a single 1, before the second 1, clears the count of 1s. For example, the stream 1,0,1,0,0,0 leaves `flag_o` at 0.
- R7: A 1 sampled during the count of 0s restarts that count but keeps the completed two-1s phase. The stream 1,1,0,0,1,0,0 leaves the flag at 0, and one more 0 raises it.
- R8: Once `flag_o` is 1, it stays 1 for any values of `bit_i` until a hold is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the design works on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Synchronous clear; while high, the machine is held idle |
| bit_i | input | 1 | Serial bit that is examined for the two runs |
| flag_o | output | 1 | Latched detection flag (Moore output) |

## Verification
Directed streams cover the following cases:

- The shortest trigger, 1,1,0,0,0, which pins the exact cycle in which the flag rises.
- A stream with unrelated bits between the two runs, which shows that the gap is allowed.
- A 1,0,1 stream, which shows that a broken 1s run is reset.
- A 1 that breaks the 0s run, which shows that the 0s count restarts while the armed phase is kept.

After the flag is raised, random bits show that it stays latched. A hold and an asynchronous reset then show that it clears. Long constrained-random streams, with occasional holds, cover gap lengths and restart points that the directed streams do not reach. Each cycle they are compared with a counter-based reference model in the bench. Every cycle is also checked between edges, which confirms that the flag is a pure Moore output.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_ARMED = 3'd2,
        ST_ZERO1 = 3'd3,
        ST_ZERO2 = 3'd4,
        ST_DONE  = 3'd5
    } rpd_state_e;
endpackage

// File: rtl/rpd_next.sv
module rpd_next
    import rpd_pkg::*;
(
    input  rpd_state_e cur_i,
    input  logic       hold_i,
    input  logic       bit_i,
    output rpd_state_e nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (hold_i) begin
            nxt_o = ST_IDLE;
        end else begin
            unique case (cur_i)
                ST_IDLE:  nxt_o = bit_i ? ST_ONE   : ST_IDLE;
                ST_ONE:   nxt_o = bit_i ? ST_ARMED : ST_IDLE;
                ST_ARMED: nxt_o = bit_i ? ST_ARMED : ST_ZERO1;
                ST_ZERO1: nxt_o = bit_i ? ST_ARMED : ST_ZERO2;
                ST_ZERO2: nxt_o = bit_i ? ST_ARMED : ST_DONE;
                ST_DONE:  nxt_o = ST_DONE;
                default:  nxt_o = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rpd_state_reg.sv
module rpd_state_reg
    import rpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rpd_state_e nxt_i,
    output rpd_state_e cur_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_o <= ST_IDLE;
        else        cur_o <= nxt_i;
    end
endmodule

// File: rtl/rpd_out.sv
module rpd_out
    import rpd_pkg::*;
(
    input  rpd_state_e cur_i,
    output logic       flag_o
);
    always_comb begin
        unique case (cur_i)
            ST_DONE: flag_o = 1'b1;
            default: flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/run_pair_detector.sv
module run_pair_detector
    import rpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic bit_i,
    output logic flag_o
);
    rpd_state_e state_q;
    rpd_state_e state_d;

    rpd_next u_next (
        .cur_i (state_q),
        .hold_i(hold_i),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    rpd_state_reg u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .nxt_i(state_d),
        .cur_o(state_q)
    );

    rpd_out u_out (
        .cur_i (state_q),
        .flag_o(flag_o)
    );
endmodule

// File: rtl/rpd_chk.sv
module rpd_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_i,
    input logic bit_i,
    input logic flag_o
);
    // R2
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !flag_o);

    // R8
    flag_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !hold_i) |=> flag_o);

    // R4
    three_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> (!$past(bit_i, 1) && !$past(bit_i, 2) && !$past(bit_i, 3)));

    // R2
    rise_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> !$past(hold_i));
endmodule

bind run_pair_detector rpd_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .hold_i(hold_i),
    .bit_i (bit_i),
    .flag_o(flag_o)
);

// File: tb/run_pair_detector_tb_top.sv
`timescale 1ns/1ps
module run_pair_detector_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_i = 1'b0;
    logic bit_i = 1'b0;
    logic flag_o;

    int checks = 0;
    int errors = 0;

    // reference model: run counters, not states
    int m_ones = 0;
    int m_zeros = 0;
    bit m_armed = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    run_pair_detector dut_i (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .bit_i(bit_i), .flag_o(flag_o)
    );

    function automatic void model_clear();
        m_ones = 0; m_zeros = 0; m_armed = 0; m_done = 0;
    endfunction

    function automatic void model_step(input logic h, input logic b);
        if (h) begin
            model_clear();
        end else if (!m_done) begin
            if (!m_armed) begin
                if (b) begin
                    m_ones++;
                    if (m_ones >= 2) begin m_armed = 1; m_zeros = 0; end
                end else begin
                    m_ones = 0;
                end
            end else begin
                if (!b) begin
                    m_zeros++;
                    if (m_zeros >= 3) m_done = 1;
                end else begin
                    m_zeros = 0;
                end
            end
        end
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flag_o=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, probe mid-cycle, probe after edge
    task automatic drive(input logic h, input logic b, input string tag);
        @(negedge clk);
        hold_i = h;
        bit_i  = b;
        #1;
        check("R3 mid-cycle", flag_o, m_done);
        @(posedge clk);
        model_step(h, b);
        #1;
        check(tag, flag_o, m_done);
    endtask

    task automatic bits(input logic [15:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) drive(1'b0, v[i], tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all R): run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        #1;
        check("R1 reset", flag_o, 1'b0);
        #20;
        @(negedge clk);
        rst_n = 1'b1;

        // R4 shortest trigger
        drive(1'b1, 1'b0, "R2 hold");
        bits(16'b1100, 4, "R4 prefix");
        check("R4 no flag after second 0", flag_o, 1'b0);
        drive(1'b0, 1'b0, "R4 third 0");
        check("R4 flag one clock after third 0", flag_o, 1'b1);

        // R8 latched
        for (int i = 0; i < 10; i++) drive(1'b0, 1'($urandom), "R8 latched");
        check("R8 still high", flag_o, 1'b1);

        // R2 hold clears
        drive(1'b1, 1'b0, "R2 hold");
        check("R2 cleared", flag_o, 1'b0);

        // R6 broken ones run
        bits(16'b101000, 6, "R6 broken ones");
        check("R6 no flag", flag_o, 1'b0);

        // R5 gap between runs
        drive(1'b1, 1'b0, "R2 hold");
        bits(16'b11101101, 8, "R5 gap");
        bits(16'b00, 2, "R5 zeros");
        check("R5 not yet", flag_o, 1'b0);
        drive(1'b0, 1'b0, "R5 third 0");
        check("R5 flag after gap", flag_o, 1'b1);

        // R7 restart of zero count
        drive(1'b1, 1'b0, "R2 hold");
        bits(16'b1100100, 7, "R7 restart");
        check("R7 no flag", flag_o, 1'b0);
        drive(1'b0, 1'b0, "R7 third 0");
        check("R7 flag", flag_o, 1'b1);

        // R1 asynchronous reset while flag high
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 async reset", flag_o, 1'b0);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;

        // random streams against the model
        for (int i = 0; i < 4000; i++) begin
            logic h;
            h = (($urandom % 40) == 0);
            drive(h, 1'($urandom), "R4/R5/R6/R7/R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule